// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block computes the memory address for one operand of a load or store. It takes up to three terms and adds them: a base register value, an index register value multiplied by a power of two, and a displacement. Each term has its own enable, so one adder covers every address form. The forms are displacement only, register indirect, base plus displacement, index plus displacement, scaled index, base plus index, base plus scaled index, and both of those with a displacement added. The block then adds the base address of the current segment, which gives the linear address.

The issuing stage drives several things in one cycle and raises `in_valid` in that cycle:

- the register-file values for base and index;
- the register number chosen for the index;
- a 2-bit scale code;
- a displacement and a width select for it;
- the segment base.

In the next cycle the block presents the registered result with `out_valid`. The stack pointer may not be used as an index. If it is selected, the block raises `illegal` and drops the index term from the sum. Segment limit checks and address translation belong to other blocks.

Top module: `agu_ea_gen`

## Requirements
- R1: After reset, `out_valid`, `illegal`, `eff_addr` and `lin_addr` are all 0.
- R2: `out_valid` is 1 in the cycle after a clock edge that sampled `in_valid`=1, and 0 in the cycle after an edge that sampled `in_valid`=0.
- R3: `eff_addr` = base term + index term + displacement term, modulo 2^32.
- R4: The index term is `index_val` shifted left by `scale_code`: code 0 multiplies by 1, code 1 by 2, code 2 by 4 and code 3 by 8.
- R5: With `disp_wide`=1 the displacement term is all 32 bits of `disp_val`. With `disp_wide`=0 it is `disp_val[7:0]` sign-extended to 32 bits, and `disp_val[31:8]` has no effect.
- R6: A term whose enable (`base_en`, `index_en` or `disp_en`) is 0 adds zero, whatever value is on its data input.
- R7: When `index_en`=1 and `index_sel`=4 (the stack pointer), `illegal` is 1 and the index term is zero. In every other case `illegal` is 0, including `index_sel`=4 with `index_en`=0.
- R8: `lin_addr` = `seg_base` + `eff_addr`, modulo 2^32.
- R9: While `in_valid` is 0, `eff_addr`, `lin_addr` and `illegal` keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | The operand inputs are valid this cycle |
| base_en | input | 1 | Include the base term |
| base_val | input | 32 | Base register value |
| index_en | input | 1 | Include the index term |
| index_sel | input | 3 | Register number of the index (4 is the stack pointer) |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Left shift applied to the index, 0 to 3 |
| disp_en | input | 1 | Include the displacement term |
| disp_wide | input | 1 | 1: 32-bit displacement, 0: 8-bit sign-extended displacement |
| disp_val | input | 32 | Displacement value |
| seg_base | input | 32 | Segment base address |
| out_valid | output | 1 | The result registers hold a new result |
| eff_addr | output | 32 | Effective address |
| lin_addr | output | 32 | Linear address |
| illegal | output | 1 | The index selected the stack pointer |

## Verification
All three results (`eff_addr`, `lin_addr` and `illegal`) come from a single register stage. Each is therefore due exactly one clock edge after the edge that samples `in_valid`, and `out_valid` marks that cycle. The driver changes inputs on the falling edge and pushes the expected result for each request into a queue. The monitor samples 2 ns after every rising edge and pops one entry for each cycle in which `out_valid` is high. It also flags any `out_valid` that has no request behind it. Hold checks run after idle cycles with junk on every input, and they sample at the same point after the rising edge.

// File: rtl/agu_ea_gen.sv
module agu_ea_gen #(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 8,
  parameter int SEL_W   = 3,
  parameter int SCALE_W = 2,
  parameter int SP_SEL  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               base_en,
  input  logic [ADDR_W-1:0]  base_val,
  input  logic               index_en,
  input  logic [SEL_W-1:0]   index_sel,
  input  logic [ADDR_W-1:0]  index_val,
  input  logic [SCALE_W-1:0] scale_code,
  input  logic               disp_en,
  input  logic               disp_wide,
  input  logic [ADDR_W-1:0]  disp_val,
  input  logic [ADDR_W-1:0]  seg_base,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  eff_addr,
  output logic [ADDR_W-1:0]  lin_addr,
  output logic               illegal
);

  localparam int EXT_W = ADDR_W - SHORT_W;

  logic              sp_hit;
  logic [ADDR_W-1:0] base_t, idx_t, disp_t, ea_d, la_d;

  assign sp_hit = index_en && (index_sel == SEL_W'(SP_SEL));
  assign base_t = base_en ? base_val : '0;
  assign idx_t  = (index_en && !sp_hit) ? (index_val << scale_code) : '0;
  assign disp_t = !disp_en  ? '0 :
                  disp_wide ? disp_val :
                  {{EXT_W{disp_val[SHORT_W-1]}}, disp_val[SHORT_W-1:0]};
  assign ea_d   = base_t + idx_t + disp_t;
  assign la_d   = seg_base + ea_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      eff_addr  <= '0;
      lin_addr  <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        eff_addr <= ea_d;
        lin_addr <= la_d;
        illegal  <= sp_hit;
      end
    end
  end

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r7_sp_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && index_en && index_sel == SEL_W'(SP_SEL)) |=> illegal);
  a_r7_no_index_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !index_en) |=> !illegal);
  a_r8_linear_sum: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (lin_addr - eff_addr) == $past(seg_base));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(eff_addr) && $stable(lin_addr) && $stable(illegal)));

endmodule

// File: tb/tb_agu_ea_gen.sv
module tb_agu_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        base_en = 1'b0, index_en = 1'b0, disp_en = 1'b0, disp_wide = 1'b0;
  logic [31:0] base_val = '0, index_val = '0, disp_val = '0, seg_base = '0;
  logic [2:0]  index_sel = '0;
  logic [1:0]  scale_code = '0;
  logic        out_valid, illegal;
  logic [31:0] eff_addr, lin_addr;

  int tests = 0, fails = 0;
  logic [64:0] exp_q[$];
  string       tag_q[$];
  logic [64:0] last_exp = '0;

  always #10 clk = ~clk;

  agu_ea_gen dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .base_en(base_en), .base_val(base_val), .index_en(index_en),
    .index_sel(index_sel), .index_val(index_val), .scale_code(scale_code),
    .disp_en(disp_en), .disp_wide(disp_wide), .disp_val(disp_val),
    .seg_base(seg_base), .out_valid(out_valid), .eff_addr(eff_addr),
    .lin_addr(lin_addr), .illegal(illegal));

  function automatic logic [64:0] model(input logic be, input logic [31:0] bv,
      input logic ie, input logic [2:0] isel, input logic [31:0] iv,
      input logic [1:0] sc, input logic de, input logic dw,
      input logic [31:0] dv, input logic [31:0] sb);
    logic [31:0] b, x, d, ea;
    logic bad;
    bad = ie && (isel == 3'd4);
    b = be ? bv : 32'd0;
    x = (ie && !bad) ? iv * (32'd1 << sc) : 32'd0;
    d = de ? (dw ? dv : 32'($signed(dv[7:0]))) : 32'd0;
    ea = b + x + d;
    return {bad, ea, sb + ea};
  endfunction

  function automatic void check(input string tag, input logic [64:0] act, input logic [64:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got ill=%0b ea=%h la=%h, expected ill=%0b ea=%h la=%h",
        tag, act[64], act[63:32], act[31:0], exp[64], exp[63:32], exp[31:0]);
    end
  endfunction

  task automatic issue(input string tag, input logic be, input logic [31:0] bv,
      input logic ie, input logic [2:0] isel, input logic [31:0] iv,
      input logic [1:0] sc, input logic de, input logic dw,
      input logic [31:0] dv, input logic [31:0] sb);
    @(negedge clk);
    base_en = be; base_val = bv; index_en = ie; index_sel = isel; index_val = iv;
    scale_code = sc; disp_en = de; disp_wide = dw; disp_val = dv; seg_base = sb;
    in_valid = 1'b1;
    last_exp = model(be, bv, ie, isel, iv, sc, de, dw, dv, sb);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      base_en = $urandom; index_en = $urandom; disp_en = $urandom; disp_wide = $urandom;
      base_val = $urandom; index_val = $urandom; disp_val = $urandom; seg_base = $urandom;
      index_sel = 3'($urandom); scale_code = 2'($urandom);
    end
  endtask

  task automatic hold_check();
    @(posedge clk); #2;
    tests++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2: out_valid=%0b while idle, expected 0", out_valid);
    end
    check("R9 hold", {illegal, eff_addr, lin_addr}, last_exp);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R2: out_valid=1 with no request, expected 0");
      end else
        check(tag_q.pop_front(), {illegal, eff_addr, lin_addr}, exp_q.pop_front());
    end
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R1 reset", {illegal, eff_addr, lin_addr}, 65'd0);
    tests++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R1: out_valid=%0b expected 0", out_valid); end
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    issue("R3 R6 direct wide", 1'b0, 32'hDEAD0000, 1'b0, 3'd1, 32'h1234, 2'd3, 1'b1, 1'b1, 32'h0000_0500, 32'h0001_0000);
    issue("R5 disp8 negative", 1'b1, 32'h0000_1000, 1'b0, 3'd0, 32'h0, 2'd0, 1'b1, 1'b0, 32'hABCD_FF80, 32'h0);
    issue("R3 reg indirect", 1'b1, 32'h0040_0000, 1'b0, 3'd2, 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b1, 32'h7777_7777, 32'h0);
    issue("R5 disp8 positive", 1'b1, 32'h0000_2000, 1'b0, 3'd0, 32'h0, 2'd0, 1'b1, 1'b0, 32'hFFFF_FF18, 32'h100);
    idle(3);
    hold_check();

    for (int s = 0; s < 4; s++)
      issue($sformatf("R4 scale code %0d", s), 1'b0, 32'h0, 1'b1, 3'd6, 32'h0000_1003, 2'(s), 1'b1, 1'b1, 32'h0000_0010, 32'h0);
    issue("R4 scale overflow", 1'b0, 32'h0, 1'b1, 3'd7, 32'hF000_0001, 2'd3, 1'b0, 1'b0, 32'h0, 32'h0);
    issue("R3 based scaled disp", 1'b1, 32'h0000_8000, 1'b1, 3'd3, 32'h0000_0020, 2'd2, 1'b1, 1'b0, 32'h0000_0050, 32'h0020_0000);
    issue("R3 wrap", 1'b1, 32'hFFFF_FFF0, 1'b1, 3'd1, 32'h0000_0010, 2'd1, 1'b1, 1'b1, 32'h0000_0008, 32'h0);
    idle(2);

    issue("R7 sp index", 1'b1, 32'h0000_3000, 1'b1, 3'd4, 32'h0BAD_0000, 2'd1, 1'b1, 1'b0, 32'h0000_0004, 32'h0);
    issue("R7 sp sel, index off", 1'b1, 32'h0000_3000, 1'b0, 3'd4, 32'h0BAD_0000, 2'd1, 1'b0, 1'b0, 32'h0, 32'h0);
    issue("R7 index 5 legal", 1'b0, 32'h0, 1'b1, 3'd5, 32'h0000_0100, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0);
    issue("R7 sp index hold", 1'b0, 32'h0, 1'b1, 3'd4, 32'h1, 2'd0, 1'b0, 1'b0, 32'h0, 32'h5);
    idle(4);
    hold_check();

    issue("R8 linear wrap", 1'b1, 32'h8000_0000, 1'b0, 3'd0, 32'h0, 2'd0, 1'b1, 1'b1, 32'h0000_0100, 32'h8000_0010);
    issue("R6 all off", 1'b0, 32'h1111_1111, 1'b0, 3'd0, 32'h2222_2222, 2'd3, 1'b0, 1'b1, 32'h3333_3333, 32'h0000_0400);
    for (int k = 0; k < 40; k++)
      issue("R3 R8 random", 1'($urandom), $urandom, 1'($urandom), 3'($urandom), $urandom,
            2'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom);
    idle(3);
    hold_check();

    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d results never appeared, expected 0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule